// File: doc/BRIEF.md
# Fine-Adjust 8-Bit Reload Timer

This block is an 8-bit down-counting timer behind a small 16-bit register port. A prescaler divides the peripheral clock by a power of two that software selects. Each prescaler output pulse is one count clock, and each count clock lowers the counter by one. When a count clock arrives while the counter sits at zero, the counter takes the reload value back and raises an underflow. The timer either keeps repeating or stops after the first underflow. Underflows set a sticky interrupt flag, and that flag drives the interrupt line through an enable bit.

The block's distinguishing part is a 4-bit trim field. Over every run of 16 underflow periods, the timer lengthens exactly that many periods by one count clock, and it spreads those periods evenly over the run. The average period can therefore be set in sixteenths of a count clock. A timer-reset strobe reloads the counter and restarts both the prescaler and the trim sequence.

Registers are addressed by a 3-bit word index. Writes take effect at the clock edge on which `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `fine_reload_timer`

## Requirements
- R1: After reset the division register reads 0x0000, the reload register 0x0000, the counter 0x00FF, the control register 0x0000 and the interrupt register 0x0000, and `irq` is low.
- R2: Register layout by word index:
  - 0 is the division code in bits [3:0].
  - 1 is the reload value in bits [7:0].
  - 2 is the counter in bits [7:0]. It is read-only, and a write there leaves it unchanged.
  - 3 is control: run in bit 0, timer-reset strobe in bit 1, one-shot in bit 2, trim count in bits [7:4].
  - 4 is interrupt: flag in bit 0, enable in bit 1.
  - Indices 5 to 7 and every bit not named above read as 0.
- R3: With division code c from 0 to 14, one count clock occurs every 2^c clock cycles while running, the first one 2^c cycles after run is set. Code 15 behaves as code 14.
- R4: While running, each count clock decrements the counter by one. A count clock at zero reloads the reload value R instead and counts as an underflow, so an untrimmed period lasts R+1 count clocks.
- R5: While the run bit is 0, the counter and the prescaler hold their values.
- R6: Writing 1 to the strobe bit loads the counter with the reload value and restarts the prescaler and the trim sequence. Writing 0 to it has no effect, and it always reads as 0.
- R7: In one-shot mode an underflow clears the run bit, and the counter then rests at the reload value.
- R8: Let j be the number of underflows since the last timer-reset strobe before a given underflow, and let k = j mod 16. The period that starts at that underflow lasts one extra count clock exactly when floor((k+1)·F/16) > floor(k·F/16), where F is the trim count. As a result, F periods out of every 16 are lengthened.
- R9: Every underflow sets the interrupt flag. Writing 1 to the flag bit clears it, writing 0 leaves it, and a set in the same cycle as a clear wins.
- R10: `irq` is high exactly when both the interrupt flag and the enable bit are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register word index |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The following hold on every cycle and are checked continuously:
- a count clock lowers the counter by one, an underflow reloads it, and it holds while stopped;
- the strobe reloads the counter and zeroes the trim phase;
- the trim phase moves only at an underflow;
- a one-shot underflow drops the run bit and every underflow raises the flag;
- `irq` stays low with the enable clear and the upper read bits stay zero.

Two properties need whole timelines and are shown only by the bench's sweeps, which measure underflow-to-underflow spacing at the counter port. The first is which periods the trim lengthens, checked for every trim count and several division codes. The second is the absolute prescaler ratio, including the two largest codes.

// File: rtl/fine_timer_pkg.sv
// Shared constants for the fine-adjust reload timer: register word
// indices and bit positions that the register file and the bench rely on.
package fine_timer_pkg;
    // Register word indices
    localparam int RIX_DIV    = 0;
    localparam int RIX_RELOAD = 1;
    localparam int RIX_COUNT  = 2;
    localparam int RIX_CTRL   = 3;
    localparam int RIX_INTR   = 4;

    // Control register bit positions
    localparam int CTRL_RUN_B    = 0;
    localparam int CTRL_CLR_B    = 1;
    localparam int CTRL_ONE_B    = 2;
    localparam int CTRL_TRIM_LSB = 4;

    // Interrupt register bit positions
    localparam int INT_FLAG_B = 0;
    localparam int INT_EN_B   = 1;
endpackage

// File: rtl/fine_timer_prescaler.sv
// Power-of-two prescaler. It emits a one-cycle count-clock pulse every
// 2^code cycles while running. Codes above DIV_MAX are clamped to DIV_MAX.
// Assumes that clear has priority over counting and that the count is
// held while stopped.
module fine_timer_prescaler #(
    parameter int DIV_SEL_W = 4,
    parameter int DIV_MAX   = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 clear,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);
    localparam logic [DIV_SEL_W-1:0] DIV_TOP = DIV_SEL_W'(DIV_MAX);

    logic [DIV_MAX-1:0]   pcnt_q;
    logic [DIV_MAX-1:0]   mask;
    logic [DIV_SEL_W-1:0] eff_sel;

    // Clamp reserved codes to the largest ratio
    assign eff_sel = (div_sel > DIV_TOP) ? DIV_TOP : div_sel;

    // Low eff_sel bits of the mask are set
    for (genvar i = 0; i < DIV_MAX; i++) begin : g_mask
        assign mask[i] = (i < int'(eff_sel));
    end

    // Pulse when the masked low bits of the counter are all ones
    assign tick = run && ((pcnt_q & mask) == mask);

    // Free-running divider counter, held while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pcnt_q <= '0;
        end else if (run) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fine_timer_core.sv
// Down counter with reload and fractional period trim. Each count clock
// lowers the counter. A count clock at zero reloads it and advances a
// phase counter. For phases chosen by an even-spread rule, the first count
// clock of the next period is swallowed, which lengthens that period by
// one. Assumes clear has priority over ticks. One-shot underflows arm no
// stretch because no period follows them.
module fine_timer_core #(
    parameter int CNT_W  = 8,
    parameter int TRIM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clear,
    input  logic              oneshot,
    input  logic [CNT_W-1:0]  reload,
    input  logic [TRIM_W-1:0] trim,
    output logic [CNT_W-1:0]  count,
    output logic [TRIM_W-1:0] phase,
    output logic              stretch,
    output logic              underflow
);
    localparam int PROD_W = 2 * TRIM_W + 1;

    logic [CNT_W-1:0]  count_q;
    logic [TRIM_W-1:0] phase_q;
    logic              stretch_q;
    logic              pick;

    // Even-spread rule: period k is lengthened when floor((k+1)F/2^W) steps
    function automatic logic stretch_pick(input logic [TRIM_W-1:0] k,
                                          input logic [TRIM_W-1:0] f);
        logic [PROD_W-1:0] lo;
        logic [PROD_W-1:0] hi;
        lo = PROD_W'(k) * PROD_W'(f);
        hi = lo + PROD_W'(f);
        return (hi >> TRIM_W) != (lo >> TRIM_W);
    endfunction

    assign pick      = stretch_pick(phase_q, trim);
    assign underflow = tick && !clear && !stretch_q && (count_q == '0);

    // Counter, phase and pending-stretch state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '1;
            phase_q   <= '0;
            stretch_q <= 1'b0;
        end else if (clear) begin
            count_q   <= reload;
            phase_q   <= '0;
            stretch_q <= 1'b0;
        end else if (tick) begin
            if (stretch_q) begin
                stretch_q <= 1'b0;
            end else if (count_q == '0) begin
                count_q   <= reload;
                phase_q   <= phase_q + 1'b1;
                stretch_q <= !oneshot && pick;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    assign count   = count_q;
    assign phase   = phase_q;
    assign stretch = stretch_q;
endmodule

// File: rtl/fine_timer_regs.sv
// Register file for the timer: division code, reload value, control and
// interrupt registers, plus the combinational read mux. Assumes one
// register access per cycle. A control write overrides a one-shot stop in
// the same cycle, and a flag set overrides a flag clear.
module fine_timer_regs
    import fine_timer_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int REG_W     = 16,
    parameter int CNT_W     = 8,
    parameter int DIV_SEL_W = 4,
    parameter int TRIM_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    input  logic [CNT_W-1:0]     count,
    input  logic                 underflow,
    output logic [DIV_SEL_W-1:0] div_sel,
    output logic [CNT_W-1:0]     reload,
    output logic                 run,
    output logic                 oneshot,
    output logic [TRIM_W-1:0]    trim,
    output logic                 int_en,
    output logic                 int_flag,
    output logic                 clr_strobe,
    output logic                 ctrl_we,
    output logic                 irq
);
    logic we_div, we_reload, we_intr;
    logic unused_wdata_hi;

    assign we_div    = we && (addr == ADDR_W'(RIX_DIV));
    assign we_reload = we && (addr == ADDR_W'(RIX_RELOAD));
    assign ctrl_we   = we && (addr == ADDR_W'(RIX_CTRL));
    assign we_intr   = we && (addr == ADDR_W'(RIX_INTR));

    assign clr_strobe      = ctrl_we && wdata[CTRL_CLR_B];
    assign unused_wdata_hi = |wdata[REG_W-1:CNT_W];

    // Division code and reload value storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_sel <= '0;
            reload  <= '0;
        end else begin
            if (we_div)    div_sel <= wdata[DIV_SEL_W-1:0];
            if (we_reload) reload  <= wdata[CNT_W-1:0];
        end
    end

    // Control fields; one-shot underflow drops run unless control is written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            oneshot <= 1'b0;
            trim    <= '0;
        end else if (ctrl_we) begin
            run     <= wdata[CTRL_RUN_B];
            oneshot <= wdata[CTRL_ONE_B];
            trim    <= wdata[CTRL_TRIM_LSB +: TRIM_W];
        end else if (underflow && oneshot) begin
            run <= 1'b0;
        end
    end

    // Interrupt enable and sticky flag with write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en   <= 1'b0;
            int_flag <= 1'b0;
        end else begin
            if (we_intr) int_en <= wdata[INT_EN_B];
            if (underflow) begin
                int_flag <= 1'b1;
            end else if (we_intr && wdata[INT_FLAG_B]) begin
                int_flag <= 1'b0;
            end
        end
    end

    // Gated interrupt line
    assign irq = int_flag && int_en;

    // Read mux; unnamed bits and indices return zero
    always_comb begin
        rdata = '0;
        case (int'(addr))
            RIX_DIV:    rdata[DIV_SEL_W-1:0] = div_sel;
            RIX_RELOAD: rdata[CNT_W-1:0]     = reload;
            RIX_COUNT:  rdata[CNT_W-1:0]     = count;
            RIX_CTRL: begin
                rdata[CTRL_RUN_B]                = run;
                rdata[CTRL_ONE_B]                = oneshot;
                rdata[CTRL_TRIM_LSB +: TRIM_W]   = trim;
            end
            RIX_INTR: begin
                rdata[INT_FLAG_B] = int_flag;
                rdata[INT_EN_B]   = int_en;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/fine_reload_timer.sv
// Top of the fine-adjust 8-bit reload timer. It ties the register file,
// the prescaler and the trimmed down counter together. Assumes a single
// clock domain and a synchronous active-low reset.
module fine_reload_timer #(
    parameter int ADDR_W    = 3,
    parameter int REG_W     = 16,
    parameter int CNT_W     = 8,
    parameter int DIV_SEL_W = 4,
    parameter int DIV_MAX   = 14,
    parameter int TRIM_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);
    logic [DIV_SEL_W-1:0] div_q;
    logic [CNT_W-1:0]     reload_q;
    logic [CNT_W-1:0]     count_q;
    logic [TRIM_W-1:0]    trim_q;
    logic [TRIM_W-1:0]    phase_q;
    logic run_q, oneshot_q, int_en_q, int_flag_q;
    logic clr_strobe, ctrl_we, tick, stretch_q, uf_pulse;

    fine_timer_regs #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W),
        .DIV_SEL_W(DIV_SEL_W), .TRIM_W(TRIM_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .rdata(bus_rdata), .count(count_q),
        .underflow(uf_pulse), .div_sel(div_q), .reload(reload_q),
        .run(run_q), .oneshot(oneshot_q), .trim(trim_q),
        .int_en(int_en_q), .int_flag(int_flag_q),
        .clr_strobe(clr_strobe), .ctrl_we(ctrl_we), .irq(irq)
    );

    fine_timer_prescaler #(
        .DIV_SEL_W(DIV_SEL_W), .DIV_MAX(DIV_MAX)
    ) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run_q), .clear(clr_strobe),
        .div_sel(div_q), .tick(tick)
    );

    fine_timer_core #(
        .CNT_W(CNT_W), .TRIM_W(TRIM_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clear(clr_strobe),
        .oneshot(oneshot_q), .reload(reload_q), .trim(trim_q),
        .count(count_q), .phase(phase_q), .stretch(stretch_q),
        .underflow(uf_pulse)
    );
endmodule

// File: rtl/fine_timer_checker.sv
// Cycle-level properties of the fine-adjust timer. Attached to the top
// module with bind; it reads internal nets that separate submodules drive.
module fine_timer_checker #(
    parameter int CNT_W  = 8,
    parameter int TRIM_W = 4,
    parameter int HI_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              stretch_q,
    input logic              uf_pulse,
    input logic              clr_strobe,
    input logic              ctrl_we,
    input logic              run_q,
    input logic              oneshot_q,
    input logic              int_en_q,
    input logic              int_flag_q,
    input logic              irq,
    input logic [CNT_W-1:0]  count_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic [TRIM_W-1:0] phase_q,
    input logic [HI_W-1:0]   rdata_hi
);
    assert_rdata_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_hi == '0);

    assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !stretch_q && (count_q != '0) && !clr_strobe
        |=> (count_q + 1'b1) == $past(count_q));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        uf_pulse |=> count_q == $past(reload_q));

    assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q && !clr_strobe |=> $stable(count_q));

    assert_strobe_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_strobe |=> (count_q == $past(reload_q)) && (phase_q == '0));

    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        uf_pulse && oneshot_q && !ctrl_we |=> !run_q);

    assert_phase_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !uf_pulse && !clr_strobe |=> $stable(phase_q));

    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        uf_pulse |=> int_flag_q);

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en_q |-> !irq);
endmodule

bind fine_reload_timer fine_timer_checker #(
    .CNT_W(CNT_W), .TRIM_W(TRIM_W), .HI_W(REG_W - CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .stretch_q(stretch_q),
    .uf_pulse(uf_pulse), .clr_strobe(clr_strobe), .ctrl_we(ctrl_we),
    .run_q(run_q), .oneshot_q(oneshot_q), .int_en_q(int_en_q),
    .int_flag_q(int_flag_q), .irq(irq), .count_q(count_q),
    .reload_q(reload_q), .phase_q(phase_q),
    .rdata_hi(bus_rdata[REG_W-1:CNT_W])
);

// File: tb/fine_reload_timer_test.sv
`timescale 1ns/1ps
module fine_reload_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = 3'd2;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    fine_reload_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Write at one edge; returns at the falling edge after it, addr on counter
    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr  = 3'(a);
        bus_wdata = 16'(d);
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = 3'd2;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = 3'(a);
        #1;
        v = int'(bus_rdata);
        bus_addr = 3'd2;
        #0.5;
    endtask

    function automatic int extra(input int j, input int f);
        int k = j % 16;
        return (((k + 1) * f) / 16 > (k * f) / 16) ? 1 : 0;
    endfunction

    // Repeat mode: measure 16 consecutive periods and compare them (R3 R4 R8)
    task automatic measure(input int d, input int f, input int r);
        int times[17];
        int nund = 0;
        int n = 0;
        int prev = r;
        int cur;
        int sum = 0;
        wr(1, r);
        wr(0, d);
        wr(3, (f << 4) | 2);
        wr(3, (f << 4) | 1);
        while (nund < 17 && n < 8000) begin
            @(negedge clk);
            n++;
            cur = int'(bus_rdata[7:0]);
            if (prev == 0 && cur == r) begin
                times[nund] = n;
                nund++;
            end
            prev = cur;
        end
        wr(3, 2);
        check("R4", $sformatf("underflows seen d=%0d f=%0d", d, f), nund, 17);
        if (nund == 17) begin
            for (int j = 0; j < 16; j++) begin
                check("R8", $sformatf("period j=%0d d=%0d f=%0d", j, d, f),
                      times[j+1] - times[j], (r + 1 + extra(j, f)) << d);
                sum += times[j+1] - times[j];
            end
            check("R3", $sformatf("16-period total d=%0d f=%0d", d, f),
                  sum, (16 * (r + 1) + f) << d);
        end
    endtask

    // One-shot from zero: cycles from run to flag equal the ratio (R3)
    task automatic ratio_wait(input int d, input int exp);
        int n = 0;
        wr(1, 0);
        wr(0, d);
        wr(4, 3);
        wr(3, 2);
        wr(3, 5);
        while (!irq && n < 40000) begin
            @(negedge clk);
            n++;
        end
        check("R3", $sformatf("cycles to underflow code %0d", d), n, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(0, v); check("R1", "division reset", v, 0);
        rd(1, v); check("R1", "reload reset", v, 0);
        rd(2, v); check("R1", "counter reset", v, 'hFF);
        rd(3, v); check("R1", "control reset", v, 0);
        rd(4, v); check("R1", "interrupt reset", v, 0);
        check("R1", "irq reset", int'(irq), 0);

        // R2 unnamed bits read zero
        wr(0, 'hFFFF); rd(0, v); check("R2", "division mask", v, 'h000F);
        wr(1, 'hFFFF); rd(1, v); check("R2", "reload mask", v, 'h00FF);
        wr(4, 'hFFFF); rd(4, v); check("R2", "interrupt mask", v, 'h0002);
        wr(3, 'hFFFF); rd(3, v); check("R2", "control mask, strobe reads 0 (R6)", v, 'h00F5);
        rd(2, v); check("R6", "strobe loaded reload", v, 'hFF);
        wr(3, 2);
        wr(5, 'hFFFF); rd(5, v); check("R2", "index 5 reads 0", v, 0);
        wr(7, 'hFFFF); rd(7, v); check("R2", "index 7 reads 0", v, 0);
        wr(4, 1);

        // R4/R5 counting then stopping
        wr(0, 0); wr(1, 200); wr(3, 2); wr(3, 1);
        repeat (10) @(negedge clk);
        wr(3, 0);
        rd(2, v); check("R4", "twelve decrements", v, 188);
        repeat (20) @(negedge clk);
        rd(2, v); check("R5", "held while stopped", v, 188);
        wr(2, 'h55); rd(2, v); check("R2", "counter ignores writes", v, 188);
        wr(3, 0); rd(2, v); check("R6", "strobe 0 has no effect", v, 188);
        wr(3, 2); rd(2, v); check("R6", "strobe reloads", v, 200);

        // R7 one-shot, R9 flag, R10 gating
        wr(1, 2); wr(4, 3); wr(3, 2); wr(3, 5);
        repeat (10) @(negedge clk);
        rd(3, v); check("R7", "run dropped after one-shot", v, 'h0004);
        rd(2, v); check("R7", "counter rests at reload", v, 2);
        rd(4, v); check("R9", "flag set by underflow", v, 'h3);
        check("R10", "irq with enable", int'(irq), 1);
        wr(4, 0); check("R10", "irq masked", int'(irq), 0);
        rd(4, v); check("R9", "writing 0 keeps flag", v, 'h1);
        wr(4, 2); check("R10", "irq unmasked", int'(irq), 1);
        wr(4, 3); check("R9", "write 1 clears flag", int'(irq), 0);
        rd(4, v); check("R9", "flag cleared readback", v, 'h2);

        // R8 trim sweep over every trim count and three division codes
        for (int f = 0; f < 16; f++) begin
            for (int d = 0; d < 3; d++) begin
                measure(d, f, 3);
            end
        end
        measure(3, 0, 3);
        measure(4, 5, 2);

        // R3 largest code and the clamped reserved code
        ratio_wait(14, 16384);
        ratio_wait(15, 16384);

        finish_run();
    end
endmodule